// File: doc/BRIEF.md
# Cycling Sample Counter with Deferred Stop

This block limits how many samples an acquisition sequence takes. A software-loaded count sets the pass length. A trigger input arms the sequence. After that, every pacer pulse that the counter accepts produces a one-clock sample enable and takes one off the working count. When the count runs out, the counter either halts, which is a single pass, or reloads and keeps sampling with no gap, which is cycling. Cycling allows runs of any length, including runs longer than one 16-bit pass.

Cycling is controlled by a control bit that is sampled only when a pass ends. If software clears that bit while a pass is running, the pass still completes, and the counter then halts at the next zero. Each zero crossing can raise an interrupt. The interrupt is a one-clock pulse plus a sticky flag, and software clears the flag by writing 1 to it. A small register write port loads the reload value, the control bits and the flag clear.

Top module: `sample_cycle_counter`

## Requirements
- R1: After reset the counter is idle and every output is 0: `running`, `count`, `sample_en`, `irq_pulse` and `irq_flag`. The stored reload value and both control bits are also 0.
- R2: A `trigger` pulse while idle sets `running` one clock later. A `trigger` while already running has no effect.
- R3: While running, each clock with `pacer` high is an accepted sample. `sample_en` is high for exactly the following clock, and `count` drops by one, unless the pass ends. Pacer pulses while idle do not change `count` and give no `sample_en`.
- R4: With the cycle bit (control bit 0) at 0, the pass ends on the sample taken while `count` is 1. The counter then halts and `count` is reloaded from the reload register, so a pass of reload value N takes exactly N samples.
- R5: With the cycle bit at 1 when a pass ends, `count` reloads and `running` stays high. The next pacer pulse is accepted with no gap.
- R6: The cycle bit is sampled only when a pass ends. Clearing it mid-pass lets the current pass finish, and the counter halts at that pass's end.
- R7: When the interrupt-enable bit (control bit 1) is 1, each pass end gives a one-clock `irq_pulse` and sets `irq_flag`. With the bit at 0, neither happens.
- R8: Writing a value with bit 0 set to address 2 clears `irq_flag`. If a pass end with interrupts enabled happens in the same clock, the flag stays set.
- R9: A reload value of 0 means a pass of 65,536 samples.
- R10: A write to address 0 stores the reload value. When idle, the write also preloads `count`. When running, the write leaves `count` alone and takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 reload, 1 control, 2 flag clear |
| wr_data | input | 16 | Write data |
| trigger | input | 1 | Starts a sequence when idle |
| pacer | input | 1 | One pulse per requested sample |
| running | output | 1 | Counter armed and counting |
| count | output | 16 | Working count (0 stands for 65,536) |
| sample_en | output | 1 | One clock per accepted sample |
| irq_pulse | output | 1 | One clock at each pass end when enabled |
| irq_flag | output | 1 | Sticky interrupt flag, write 1 to clear |

## Verification
The bound checker looks at every cycle. It checks that a sample enable only follows a running cycle, that `count` holds between pacer pulses and drops by exactly one on each mid-pass sample, that an idle counter stays idle without a trigger, and that a pulse always comes with the flag and with interrupts enabled. It also checks that a pass end halts or continues according to the cycle bit. The bench's scenarios are needed to show the rest, because they follow a whole sequence: the deferred stop after clearing the cycle bit, a reload written mid-run taking effect only on the next pass, a full 65,536-sample pass for a zero reload value, and the flag-clear priority.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_RELOAD = 2'd0,
    REG_CTRL   = 2'd1,
    REG_STATUS = 2'd2
  } reg_sel_e;

  localparam int unsigned CTRL_CYCLE_BIT = 0;
  localparam int unsigned CTRL_IEN_BIT   = 1;
  localparam int unsigned STAT_FLAG_BIT  = 0;
endpackage

// File: rtl/scc_regs.sv
module scc_regs
  import scc_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] reload,
  output logic          cycle_en,
  output logic          irq_en,
  output logic          preload,
  output logic          flag_clr
);
  logic [CW-1:0] reload_q, reload_d;
  logic          cyc_q, cyc_d, ien_q, ien_d;
  logic          sel_reload, sel_ctrl, sel_stat;

  assign sel_reload = wr_en && (wr_addr == AW'(REG_RELOAD));
  assign sel_ctrl   = wr_en && (wr_addr == AW'(REG_CTRL));
  assign sel_stat   = wr_en && (wr_addr == AW'(REG_STATUS));

  always_comb begin
    reload_d = reload_q;
    cyc_d    = cyc_q;
    ien_d    = ien_q;
    if (sel_reload) reload_d = wr_data;
    if (sel_ctrl) begin
      cyc_d = wr_data[CTRL_CYCLE_BIT];
      ien_d = wr_data[CTRL_IEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cyc_q    <= 1'b0;
      ien_q    <= 1'b0;
    end else begin
      if (sel_reload) reload_q <= reload_d;
      if (sel_ctrl) begin
        cyc_q <= cyc_d;
        ien_q <= ien_d;
      end
    end
  end

  assign reload   = reload_q;
  assign cycle_en = cyc_q;
  assign irq_en   = ien_q;
  assign preload  = sel_reload;
  assign flag_clr = sel_stat && wr_data[STAT_FLAG_BIT];
endmodule

// File: rtl/scc_core.sv
module scc_core
  import scc_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trigger,
  input  logic          pacer,
  input  logic [CW-1:0] reload,
  input  logic          cycle_en,
  input  logic          preload,
  input  logic [CW-1:0] preload_val,
  output logic          running,
  output logic [CW-1:0] count,
  output logic          sample_en,
  output logic          pass_end
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sen_q, sen_d;
  logic          accept, last;

  assign accept = run_q && pacer;
  assign last   = accept && (cnt_q == ONE);

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    sen_d = accept;
    if (!run_q) begin
      if (preload) cnt_d = preload_val;
      if (trigger) run_d = 1'b1;
    end else if (accept) begin
      if (last) begin
        cnt_d = reload;
        run_d = cycle_en;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      sen_q <= 1'b0;
    end else begin
      run_q <= run_d;
      sen_q <= sen_d;
      if (accept || (!run_q && preload)) cnt_q <= cnt_d;
    end
  end

  assign running   = run_q;
  assign count     = cnt_q;
  assign sample_en = sen_q;
  assign pass_end  = last;
endmodule

// File: rtl/scc_irq.sv
module scc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic pass_end,
  input  logic irq_en,
  input  logic flag_clr,
  output logic irq_pulse,
  output logic irq_flag
);
  logic pulse_q, pulse_d, flag_q, flag_d;

  always_comb begin
    pulse_d = pass_end && irq_en;
    flag_d  = pulse_d || (flag_q && !flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      flag_q  <= flag_d;
    end
  end

  assign irq_pulse = pulse_q;
  assign irq_flag  = flag_q;
endmodule

// File: rtl/sample_cycle_counter.sv
module sample_cycle_counter
  import scc_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          trigger,
  input  logic          pacer,
  output logic          running,
  output logic [CW-1:0] count,
  output logic          sample_en,
  output logic          irq_pulse,
  output logic          irq_flag
);
  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic [CW-1:0] reload;
  logic          cycle_en, irq_en, preload, flag_clr, pass_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  scc_regs #(.CW(CW), .AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .reload(reload), .cycle_en(cycle_en),
    .irq_en(irq_en), .preload(preload), .flag_clr(flag_clr)
  );

  scc_core #(.CW(CW)) core_i (
    .clk(clk), .rst_n(rst_n_s), .trigger(trigger), .pacer(pacer),
    .reload(reload), .cycle_en(cycle_en), .preload(preload),
    .preload_val(wr_data), .running(running), .count(count),
    .sample_en(sample_en), .pass_end(pass_end)
  );

  scc_irq irq_i (
    .clk(clk), .rst_n(rst_n_s), .pass_end(pass_end), .irq_en(irq_en),
    .flag_clr(flag_clr), .irq_pulse(irq_pulse), .irq_flag(irq_flag)
  );
endmodule

// File: rtl/scc_chk.sv
module scc_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trigger,
  input logic          pacer,
  input logic          running,
  input logic [CW-1:0] count,
  input logic          sample_en,
  input logic          irq_pulse,
  input logic          irq_flag,
  input logic          cycle_en,
  input logic          irq_en
);
  // R3
  sen_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> $past(running));
  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !pacer) |=> $stable(count));
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pacer && count != CW'(1)) |=> (count == CW'($past(count) - CW'(1))));
  // R2
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !trigger) |=> !running);
  // R7
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_flag);
  // R7
  pulse_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(irq_en));
  // R4
  single_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pacer && count == CW'(1) && !cycle_en) |=> !running);
  // R5
  cycle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pacer && count == CW'(1) && cycle_en) |=> running);
endmodule

bind sample_cycle_counter scc_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .trigger(trigger), .pacer(pacer),
  .running(running), .count(count), .sample_en(sample_en),
  .irq_pulse(irq_pulse), .irq_flag(irq_flag), .cycle_en(cycle_en),
  .irq_en(irq_en)
);

// File: tb/sample_cycle_counter_tb_top.sv
module sample_cycle_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        trigger = 1'b0;
  logic        pacer = 1'b0;
  logic        running, sample_en, irq_pulse, irq_flag;
  logic [15:0] count;

  int    n_chk = 0, n_fail = 0, cycles = 0, n_irq = 0;
  bit    chk_on = 1'b0;
  string cur_req = "R1";

  // reference state
  bit m_run, m_cyc, m_ien, m_flag, m_sen, m_irqp;
  int m_rem, m_reload;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_cycle_counter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trigger(trigger), .pacer(pacer),
    .running(running), .count(count), .sample_en(sample_en),
    .irq_pulse(irq_pulse), .irq_flag(irq_flag)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_cyc = 0; m_ien = 0; m_flag = 0; m_sen = 0; m_irqp = 0;
      m_rem = 65536; m_reload = 0;
    end else begin
      bit acc, fin, ien_old;
      acc = m_run && pacer;
      fin = acc && (m_rem == 1);
      ien_old = m_ien;
      m_sen = acc;
      m_irqp = fin && ien_old;
      if (!m_run) begin
        if (wr_en && wr_addr == 2'd0) m_rem = (wr_data == 0) ? 65536 : int'(wr_data);
        if (trigger) m_run = 1;
      end else if (acc) begin
        if (fin) begin
          m_rem = (m_reload == 0) ? 65536 : m_reload;
          m_run = m_cyc;
        end else m_rem = m_rem - 1;
      end
      if (fin && ien_old) m_flag = 1;
      else if (wr_en && wr_addr == 2'd2 && wr_data[0]) m_flag = 0;
      if (wr_en && wr_addr == 2'd0) m_reload = int'(wr_data);
      if (wr_en && wr_addr == 2'd1) begin m_cyc = wr_data[0]; m_ien = wr_data[1]; end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (irq_pulse) n_irq++;
    if (chk_on) begin
      logic [19:0] act, exp;
      act = {running, count, sample_en, irq_pulse, irq_flag};
      exp = {m_run, m_rem[15:0], m_sen, m_irqp, m_flag};
      n_chk++;
      if (act !== exp) begin
        n_fail++;
        $display("FAIL %s cycle %0d: actual run=%0b cnt=%0d sen=%0b irq=%0b flag=%0b expected run=%0b cnt=%0d sen=%0b irq=%0b flag=%0b",
          cur_req, cycles, act[19], act[18:3], act[2], act[1], act[0],
          exp[19], exp[18:3], exp[2], exp[1], exp[0]);
      end
    end
    if (cycles > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 0; trigger = 0; pacer = 0;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; trigger = 0; pacer = 0;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic trig();
    @(negedge clk);
    trigger = 1; pacer = 0;
    @(negedge clk);
    trigger = 0;
  endtask

  task automatic pace(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pacer = 1; trigger = 0; wr_en = 0;
      if (gap > 0) begin
        @(negedge clk);
        pacer = 0;
        idle(gap - 1);
      end
    end
    @(negedge clk);
    pacer = 0;
  endtask

  task automatic expect_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk_on = 1;
    cur_req = "R1";
    idle(2);
    expect_bit("R1", running, 1'b0);

    cur_req = "R10";            // idle preload of count
    wr(2'd0, 16'd5);
    idle(1);
    cur_req = "R3";             // pacer while idle is ignored
    pace(4, 1);
    expect_bit("R3", running, 1'b0);

    cur_req = "R2";
    wr(2'd1, 16'h0002);         // irq on, single pass
    trig();
    trig();                     // trigger while running: no effect
    cur_req = "R4";
    pace(5, 2);
    idle(2);
    expect_bit("R4", running, 1'b0);
    cur_req = "R8";
    wr(2'd2, 16'h0001);
    idle(1);
    expect_bit("R8", irq_flag, 1'b0);

    cur_req = "R5";
    wr(2'd0, 16'd3);
    wr(2'd1, 16'h0003);
    trig();
    n_irq = 0;
    pace(7, 0);
    cur_req = "R6";
    wr(2'd1, 16'h0002);         // clear cycle bit mid pass
    pace(2, 1);
    idle(2);
    expect_bit("R6", running, 1'b0);
    expect_bit("R7", n_irq == 3, 1'b1);
    pace(3, 0);                 // after halt, ignored

    cur_req = "R8";             // clear and set in the same clock
    wr(2'd0, 16'd1);
    wr(2'd1, 16'h0002);
    trig();
    @(negedge clk);
    pacer = 1; wr_en = 1; wr_addr = 2'd2; wr_data = 16'h0001;
    @(negedge clk);
    pacer = 0; wr_en = 0;
    idle(1);
    expect_bit("R8", irq_flag, 1'b1);

    cur_req = "R10";            // reload written while running
    wr(2'd0, 16'd4);
    wr(2'd1, 16'h0001);         // cycle on, irq off
    trig();
    pace(2, 0);
    wr(2'd0, 16'd2);
    pace(2, 0);
    wr(2'd1, 16'h0000);
    pace(2, 0);
    idle(2);
    expect_bit("R10", running, 1'b0);

    cur_req = "R7";             // irq disabled: no pulse
    n_irq = 0;
    wr(2'd0, 16'd2);
    trig();
    pace(2, 1);
    idle(2);
    expect_bit("R7", n_irq == 0, 1'b1);

    cur_req = "R9";             // zero reload = 65536 samples
    wr(2'd1, 16'h0002);
    wr(2'd0, 16'd0);
    trig();
    n_irq = 0;
    pace(65535, 0);
    idle(2);
    expect_bit("R9", running, 1'b1);
    pace(1, 0);
    idle(2);
    expect_bit("R9", running, 1'b0);
    expect_bit("R9", n_irq == 1, 1'b1);

    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule